// File: doc/BRIEF.md
# Serial Register Access Front End for a Quad Potentiometer Bank

This block is the slave side of a mode-0 SPI link that gives a host access to the register bank of four digital potentiometers. It runs on a fast system clock and watches the serial clock, chip select and data input for edges. Each chip-select window is split into three parts. First comes a fixed device code byte. Next comes a command byte that carries an operation and a starting register number. Any number of data bytes follow.

On a write, every complete data byte becomes a one-cycle write strobe toward the bank, with its own address and data. On a read, the addressed register is shifted out on an open-drain style output while the host clocks in dummy bytes. In both cases a register pointer steps forward after each byte and wraps back to zero after address 6. While the bank reports a non-volatile cycle in progress, writes are refused. A bad device code or an unknown operation silences the rest of the window.

The serial clock must stay high for at least 3 system clocks and low for at least 3 system clocks.

Top module: `pot_spi_regif`

## Requirements
- R1: While chip select is high, or while reset is asserted, `spi_sdo_low` is 0 (output released) and no write strobe is issued.
- R2: The first byte of a window, sampled MSB first on rising serial-clock edges, must equal 0x50. Any other value makes the rest of the window produce no strobe and no output drive.
- R3: The second byte carries the operation in bits 7:4 and the start address in bits 3:0. Operation 0xC (write) turns each complete data byte into one `reg_we` pulse of one system clock, with `reg_wdata` set to the byte and `reg_addr` set to the current pointer.
- R4: An operation code other than 0xB or 0xC makes the rest of the window produce no strobe and no output drive.
- R5: After each complete data byte the pointer advances by one. From any address of 6 or above it wraps to 0, so a burst starting at 5 addresses 5, 6, 0, 1 and so on.
- R6: Operation 0xB (read) presents the register at the start address on the output, MSB first. Each bit changes after a falling serial-clock edge, starting with the falling edge that follows the command byte. A 0 bit drives `spi_sdo_low` to 1, and a 1 bit leaves it at 0.
- R7: A read continues for as long as the host clocks. Each further byte comes from the next pointer value, following the wrap rule of R5, and the data input is ignored.
- R8: A data byte that completes while `reg_busy` is 1 produces no strobe, but the pointer still advances.
- R9: A data byte left incomplete when chip select rises produces no strobe.
- R10: After reset, no transaction is accepted until chip select has been seen high. A window already open when reset ends is ignored.
- R11: Chip select going high clears the bit counter and framing state, so the next window starts again with the device code byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sdi | input | 1 | Serial data from host |
| spi_sdo_low | output | 1 | 1 pulls the shared data-out line low; 0 releases it |
| reg_addr | output | 4 | Register pointer presented to the bank |
| reg_wdata | output | 8 | Write data for the bank |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data from the bank at `reg_addr` |
| reg_busy | input | 1 | Non-volatile write in progress; blocks strobes |

## Verification
A wrong framing state shows up in the same window. A window that should be dead still produces strobes or drives the output, or a valid window produces none. A bad bit counter shifts the strobe data, so it is wrong by one bit position from the first data byte onward. A pointer error appears on the second byte of a burst, either as the strobe address or as the read byte that comes back. The wrap is exercised by bursts that cross address 6 from below and from above.

// File: rtl/pot_spi_regif.sv
module pot_spi_regif #(
  parameter int          AW        = 4,
  parameter int          BW        = 8,
  parameter logic [7:0]  DEV_CODE  = 8'h50,
  parameter logic [3:0]  OP_READ   = 4'hB,
  parameter logic [3:0]  OP_WRITE  = 4'hC,
  parameter int          LAST_ADDR = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sck,
  input  logic          spi_cs_n,
  input  logic          spi_sdi,
  output logic          spi_sdo_low,
  output logic [AW-1:0] reg_addr,
  output logic [BW-1:0] reg_wdata,
  output logic          reg_we,
  input  logic [BW-1:0] reg_rdata,
  input  logic          reg_busy
);
  localparam int CW = $clog2(BW);

  typedef enum logic [1:0] {PH_ID, PH_CMD, PH_DATA, PH_DEAD} phase_t;

  phase_t        phase;
  logic          sck_q, is_rd, step, load, out_on, out_bit;
  logic [CW-1:0] bitcnt;
  logic [BW-1:0] shin, txreg;
  logic [AW-1:0] ptr;

  wire          rise    = spi_sck & ~sck_q & ~spi_cs_n;
  wire          fall    = ~spi_sck & sck_q & ~spi_cs_n;
  wire [BW-1:0] byte_in = {shin[BW-2:0], spi_sdi};
  wire          done    = rise && (bitcnt == CW'(BW-1));
  wire [AW-1:0] ptr_nxt = (ptr >= AW'(LAST_ADDR)) ? '0 : ptr + 1'b1;
  wire [3:0]    op      = byte_in[7:4];

  assign reg_addr    = ptr;
  assign spi_sdo_low = out_on & ~out_bit & ~spi_cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_DEAD;
      sck_q     <= 1'b0;
      is_rd     <= 1'b0;
      step      <= 1'b0;
      load      <= 1'b0;
      out_on    <= 1'b0;
      out_bit   <= 1'b1;
      bitcnt    <= '0;
      shin      <= '0;
      txreg     <= '0;
      ptr       <= '0;
      reg_we    <= 1'b0;
      reg_wdata <= '0;
    end else begin
      sck_q  <= spi_sck;
      reg_we <= 1'b0;
      step   <= 1'b0;
      load   <= 1'b0;
      if (step) begin
        ptr <= ptr_nxt;
        if (is_rd) load <= 1'b1;
      end
      if (load) txreg <= reg_rdata;
      if (spi_cs_n) begin
        phase  <= PH_ID;
        bitcnt <= '0;
        is_rd  <= 1'b0;
        out_on <= 1'b0;
      end else begin
        if (rise) begin
          shin   <= byte_in;
          bitcnt <= bitcnt + 1'b1;
        end
        if (done) begin
          case (phase)
            PH_ID:   phase <= (byte_in == DEV_CODE) ? PH_CMD : PH_DEAD;
            PH_CMD: begin
              if (op == OP_READ || op == OP_WRITE) begin
                phase <= PH_DATA;
                ptr   <= byte_in[AW-1:0];
                is_rd <= (op == OP_READ);
                load  <= (op == OP_READ);
              end else begin
                phase <= PH_DEAD;
              end
            end
            PH_DATA: begin
              step <= 1'b1;
              if (!is_rd && !reg_busy) begin
                reg_we    <= 1'b1;
                reg_wdata <= byte_in;
              end
            end
            default: phase <= PH_DEAD;
          endcase
        end
        if (fall && phase == PH_DATA && is_rd) begin
          out_bit <= txreg[BW-1];
          txreg   <= {txreg[BW-2:0], 1'b0};
          out_on  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pot_spi_regif_chk.sv
module pot_spi_regif_chk #(
  parameter int AW        = 4,
  parameter int LAST_ADDR = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          spi_cs_n,
  input logic          spi_sdo_low,
  input logic          reg_we,
  input logic          reg_busy,
  input logic [AW-1:0] reg_addr
);
  // R1
  sdo_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sdo_low);

  // R9
  no_strobe_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |=> !reg_we);

  // R8
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !$past(reg_busy));

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> reg_addr == (($past(reg_addr) >= AW'(LAST_ADDR)) ? '0 : $past(reg_addr) + 1'b1));
endmodule

bind pot_spi_regif pot_spi_regif_chk #(.AW(AW), .LAST_ADDR(LAST_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sdo_low(spi_sdo_low),
  .reg_we(reg_we), .reg_busy(reg_busy), .reg_addr(reg_addr)
);

// File: tb/pot_spi_regif_test.sv
module pot_spi_regif_test;
  logic clk = 0, rst_n = 0, sck = 0, cs_n = 0, sdi = 0, busy = 0;
  logic sdo_low, we;
  logic [3:0] addr;
  logic [7:0] wdata, rdata;
  logic [7:0] bank [16];
  logic [3:0] log_a [32];
  logic [7:0] log_d [32];
  int nlog = 0, lows = 0, tests = 0, fails = 0;

  always #10 clk = ~clk;

  pot_spi_regif uut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_sdi(sdi),
    .spi_sdo_low(sdo_low), .reg_addr(addr), .reg_wdata(wdata), .reg_we(we),
    .reg_rdata(rdata), .reg_busy(busy)
  );

  assign rdata = bank[addr];

  always @(posedge clk) if (we) begin
    bank[addr] = wdata;
    if (nlog < 32) begin log_a[nlog] = addr; log_d[nlog] = wdata; end
    nlog = nlog + 1;
  end

  function automatic logic [3:0] nxt(input logic [3:0] a);
    return (a >= 4'd6) ? 4'd0 : a + 4'd1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, input int nbits);
    rx = 8'hFF;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk) sdi = tx[7-i];
      repeat (3) @(negedge clk);
      rx[7-i] = ~sdo_low;
      if (sdo_low) lows++;
      sck = 1;
      repeat (4) @(negedge clk);
      sck = 0;
    end
  endtask

  task automatic open_cs();
    @(negedge clk) cs_n = 0;
    nlog = 0; lows = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic close_cs();
    repeat (4) @(negedge clk);
    cs_n = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic wr_burst(input logic [7:0] id, input logic [7:0] cmd, input int n, input int seed);
    logic [7:0] rx;
    xfer(id, rx, 8);
    xfer(cmd, rx, 8);
    for (int k = 0; k < n; k++) xfer(8'((seed + 37 * k) ^ 8'h5A), rx, 8);
  endtask

  task automatic expect_writes(input logic [3:0] start, input int n, input int seed, input string req);
    logic [3:0] a = start;
    chk(nlog == n, req, nlog, n);
    for (int k = 0; k < n && k < nlog && k < 32; k++) begin
      chk(log_a[k] == a, req, log_a[k], a);
      chk(log_d[k] == 8'((seed + 37 * k) ^ 8'h5A), req, log_d[k], 8'((seed + 37 * k) ^ 8'h5A));
      a = nxt(a);
    end
  endtask

  task automatic rd_burst(input logic [3:0] start, input int n, input string req);
    logic [7:0] rx;
    logic [3:0] a = start;
    xfer(8'h50, rx, 8);
    xfer({4'hB, start}, rx, 8);
    for (int k = 0; k < n; k++) begin
      xfer(8'($urandom), rx, 8);
      chk(rx == bank[a], req, rx, bank[a]);
      a = nxt(a);
    end
  endtask

  initial begin
    logic [7:0] rx;
    void'($urandom(32'd2024));
    for (int i = 0; i < 16; i++) bank[i] = 8'(i * 17 + 3);
    repeat (3) @(negedge clk);
    chk(sdo_low == 0 && we == 0, "R1 reset", {sdo_low, we}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    nlog = 0;
    // R10: window open across reset release is ignored
    wr_burst(8'h50, 8'hC1, 2, 9);
    close_cs();
    chk(nlog == 0, "R10", nlog, 0);

    // R3 single write
    open_cs(); wr_burst(8'h50, 8'hC2, 1, 1); close_cs();
    expect_writes(4'd2, 1, 1, "R3");
    chk(bank[2] == 8'(1 ^ 8'h5A), "R3 bank", bank[2], 8'(1 ^ 8'h5A));

    // R5 wrap from 5 and from 8
    open_cs(); wr_burst(8'h50, 8'hC5, 9, 7); close_cs();
    expect_writes(4'd5, 9, 7, "R5");
    open_cs(); wr_burst(8'h50, 8'hC8, 2, 11); close_cs();
    expect_writes(4'd8, 2, 11, "R5 above");

    // R2 bad id, write and read
    open_cs(); wr_burst(8'h51, 8'hC1, 2, 3); close_cs();
    chk(nlog == 0, "R2 write", nlog, 0);
    bank[1] = 8'h00;
    open_cs(); xfer(8'hD0, rx, 8); xfer(8'hB1, rx, 8); xfer(8'h00, rx, 8); xfer(8'h00, rx, 8); close_cs();
    chk(lows == 0, "R2 read", lows, 0);

    // R4 bad op
    open_cs(); wr_burst(8'h50, 8'hA3, 2, 5); close_cs();
    chk(nlog == 0, "R4 write", nlog, 0);
    open_cs(); wr_burst(8'h50, 8'h11, 2, 5); close_cs();
    chk(nlog == 0 && lows == 0, "R4 read", nlog + lows, 0);

    // R6 R7 read burst across wrap
    for (int i = 0; i < 16; i++) bank[i] = 8'($urandom);
    bank[3] = 8'h00; bank[4] = 8'hFF;
    open_cs(); rd_burst(4'd3, 6, "R6 R7"); close_cs();
    chk(nlog == 0, "R7 no strobe", nlog, 0);

    // R8 busy
    busy = 1;
    open_cs(); wr_burst(8'h50, 8'hC0, 3, 13); close_cs();
    busy = 0;
    chk(nlog == 0, "R8", nlog, 0);

    // R9 partial bytes
    open_cs(); xfer(8'h50, rx, 8); xfer(8'hC4, rx, 8); xfer(8'hAA, rx, 5); close_cs();
    chk(nlog == 0, "R9 partial", nlog, 0);
    open_cs(); xfer(8'h50, rx, 8); xfer(8'hC4, rx, 8); xfer(8'h3C, rx, 8); xfer(8'hAA, rx, 3); close_cs();
    chk(nlog == 1 && log_a[0] == 4'd4 && log_d[0] == 8'h3C, "R9 full+partial", nlog, 1);

    // R11 abort mid command, then fresh window
    open_cs(); xfer(8'h50, rx, 8); xfer(8'hC0, rx, 4); close_cs();
    chk(nlog == 0, "R11 abort", nlog, 0);
    open_cs(); wr_burst(8'h50, 8'hC6, 2, 21); close_cs();
    expect_writes(4'd6, 2, 21, "R11");

    // random mix
    for (int t = 0; t < 40; t++) begin
      logic [3:0] st = 4'($urandom % 9);
      int n = 1 + int'($urandom % 9);
      if ($urandom % 2) begin
        int sd = int'($urandom % 256);
        busy = ($urandom % 4) == 0;
        open_cs(); wr_burst(8'h50, {4'hC, st}, n, sd); close_cs();
        if (busy) chk(nlog == 0, "R8 random", nlog, 0);
        else expect_writes(st, n, sd, "R3 R5 random");
        busy = 0;
      end else begin
        open_cs(); rd_burst(st, n, "R6 R7 random"); close_cs();
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule